// File: doc/BRIEF.md
# Flash Power-Up Instruction Gate

This block sits ahead of the command decoder in a serial flash device model. It watches two supply comparator flags, one for the write-inhibit threshold and one for the minimum operating level. From them it decides when opcodes coming off the serial shifter may run. Below the write-inhibit threshold it holds the core state in reset, so the device neither answers nor acts. Above that threshold, two independent delay counters run, each from a different threshold. One enables read-class access and the other enables write-class access.

Opcodes arrive as a byte-valid strobe qualified by an active-low chip select. Each strobe that the gate sees produces one accept or reject pulse one cycle later. An accepted opcode updates the small amount of core state owned here: the write enable latch and the standby / deep power-down mode.

A supply drop while the array reports a write in progress sets a sticky corruption-risk flag. Only a host acknowledge clears it, and the supply-driven reset leaves it alone.

Top module: `flash_pwr_gate`

## Requirements
- R1: While `vwi_ok_i` is low, `read_ok_o`, `write_ok_o`, `wel_o` and `deep_pd_o` are low in the same cycle, and no accept or reject pulse is produced. On the next clock edge the write enable latch and the mode are cleared.
- R2: `write_ok_o` rises on the T_PUW-th rising edge after `vwi_ok_i` goes high and stays high. It also requires `read_ok_o`.
- R3: `read_ok_o` rises on the T_VSL-th rising edge after both `vwi_ok_i` and `vmin_ok_i` are high. This does not depend on the write delay.
- R4: Either delay counter restarts from zero whenever its enabling flag drops. Access is lost in the same cycle and returns only after the full delay.
- R5: The write class is the set of opcodes 0x06, 0x02, 0xD8, 0xC7 and 0x01. While `read_ok_o` is high and `write_ok_o` is low, a write-class opcode is rejected and every other opcode, including read 0x03, is accepted.
- R6: A rejected write-enable opcode (0x06) leaves `wel_o` low.
- R7: An accepted 0x06 sets `wel_o` on the same edge as the accept pulse. An accepted 0x04 clears it.
- R8: After reset and after every supply-driven reset, `deep_pd_o` is low (standby). An accepted 0xB9 sets it and an accepted 0xAB clears it.
- R9: With `cs_ni` high, or while `read_ok_o` is low, a strobe produces neither an accept nor a reject pulse.
- R10: If `wip_i` is high on the edge that samples `vwi_ok_i` falling, `risk_o` is set. It stays set until a cycle with `risk_ack_i` high.
- R11: An accept or reject pulse lasts exactly one cycle and appears on the edge that samples the strobe. `op_o` shows the opcode that produced it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Model clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| vwi_ok_i | input | 1 | Supply above write-inhibit threshold |
| vmin_ok_i | input | 1 | Supply above minimum operating level |
| cs_ni | input | 1 | Chip select, active low |
| op_valid_i | input | 1 | Opcode byte valid strobe |
| op_i | input | 8 | Opcode byte |
| wip_i | input | 1 | Array write/program/erase in progress |
| risk_ack_i | input | 1 | Host acknowledge of the corruption-risk flag |
| read_ok_o | output | 1 | Read-class instructions permitted |
| write_ok_o | output | 1 | Write-class instructions permitted |
| acc_o | output | 1 | One-cycle accept pulse |
| rej_o | output | 1 | One-cycle reject pulse |
| op_o | output | 8 | Opcode belonging to the last pulse |
| wel_o | output | 1 | Write enable latch |
| deep_pd_o | output | 1 | Deep power-down mode (0 = standby) |
| risk_o | output | 1 | Sticky corruption-risk flag |

## Verification
A delay counter that is off by one cycle moves the rising edge of `read_ok_o` or `write_ok_o` by one clock. The bench therefore samples one cycle before each boundary and on the boundary itself. A counter that fails to restart shows as access returning early after a brief comparator dropout. A write enable latch that survives a rejected opcode or a supply-driven reset shows on `wel_o` one edge after the event. A risk flag that is set on the wrong edge, or cleared without an acknowledge, shows on `risk_o` by the next cycle.

// File: rtl/flash_gate_pkg.sv
package flash_gate_pkg;

  typedef enum logic [7:0] {
    OP_WRSR = 8'h01,
    OP_PP   = 8'h02,
    OP_READ = 8'h03,
    OP_WRDI = 8'h04,
    OP_WREN = 8'h06,
    OP_RDP  = 8'hAB,
    OP_DP   = 8'hB9,
    OP_BE   = 8'hC7,
    OP_SE   = 8'hD8
  } opcode_e;

  function automatic logic is_write_class(logic [7:0] op);
    case (op)
      OP_WREN, OP_PP, OP_SE, OP_BE, OP_WRSR: return 1'b1;
      default:                               return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/pg_delay_cnt.sv
module pg_delay_cnt #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!en_i)             cnt_q <= '0;
    else if (cnt_q != CW'(LIMIT)) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = en_i && (cnt_q == CW'(LIMIT));

  p_cnt_restart_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0));

  p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(LIMIT));

endmodule

// File: rtl/pg_op_filter.sv
module pg_op_filter
  import flash_gate_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       core_en_i,
  input  logic       cs_ni,
  input  logic       op_valid_i,
  input  logic [7:0] op_i,
  input  logic       read_ok_i,
  input  logic       write_ok_i,
  output logic       acc_now_o,
  output logic       acc_o,
  output logic       rej_o,
  output logic [7:0] op_o
);
  logic       strobe, allowed;
  logic       acc_q, rej_q;
  logic [7:0] op_q;

  // chip select counts as deselected until reads are permitted
  assign strobe    = core_en_i && read_ok_i && !cs_ni && op_valid_i;
  assign allowed   = !is_write_class(op_i) || write_ok_i;
  assign acc_now_o = strobe && allowed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= 1'b0;
      rej_q <= 1'b0;
      op_q  <= '0;
    end else if (!core_en_i) begin
      acc_q <= 1'b0;
      rej_q <= 1'b0;
      op_q  <= '0;
    end else begin
      acc_q <= acc_now_o;
      rej_q <= strobe && !allowed;
      if (strobe) op_q <= op_i;
    end
  end

  assign acc_o = acc_q;
  assign rej_o = rej_q;
  assign op_o  = op_q;

  p_write_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe && is_write_class(op_i) && !write_ok_i) |=> (rej_q && !acc_q));

  p_cs_block_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni || !read_ok_i) |=> (!acc_q && !rej_q));

  p_pulse_len_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_q && !strobe) |=> !acc_q);

endmodule

// File: rtl/pg_core_state.sv
module pg_core_state
  import flash_gate_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       core_en_i,
  input  logic       acc_i,
  input  logic [7:0] op_i,
  output logic       wel_o,
  output logic       deep_pd_o
);
  logic wel_q, dp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_q <= 1'b0;
      dp_q  <= 1'b0;
    end else if (!core_en_i) begin
      wel_q <= 1'b0;
      dp_q  <= 1'b0;
    end else if (acc_i) begin
      case (op_i)
        OP_WREN: wel_q <= 1'b1;
        OP_WRDI: wel_q <= 1'b0;
        OP_DP:   dp_q  <= 1'b1;
        OP_RDP:  dp_q  <= 1'b0;
        default: ;
      endcase
    end
  end

  assign wel_o     = wel_q && core_en_i;
  assign deep_pd_o = dp_q && core_en_i;

  p_core_clear_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !core_en_i |=> (!wel_q && !dp_q));

  p_wel_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_en_i && acc_i && op_i == OP_WREN) |=> wel_q);

  p_wel_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_en_i && !(acc_i && (op_i == OP_WREN || op_i == OP_WRDI))) |=> $stable(wel_q));

endmodule

// File: rtl/pg_risk_flag.sv
module pg_risk_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vwi_ok_i,
  input  logic wip_i,
  input  logic ack_i,
  output logic risk_o
);
  logic vwi_d, risk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vwi_d  <= 1'b0;
      risk_q <= 1'b0;
    end else begin
      vwi_d <= vwi_ok_i;
      if (vwi_d && !vwi_ok_i && wip_i) risk_q <= 1'b1;
      else if (ack_i)                   risk_q <= 1'b0;
    end
  end

  assign risk_o = risk_q;

  p_risk_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vwi_d && !vwi_ok_i && wip_i) |=> risk_q);

  p_risk_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (risk_q && !ack_i) |=> risk_q);

endmodule

// File: rtl/flash_pwr_gate.sv
module flash_pwr_gate
  import flash_gate_pkg::*;
#(
  parameter int unsigned T_PUW = 40,
  parameter int unsigned T_VSL = 12
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       vwi_ok_i,
  input  logic       vmin_ok_i,
  input  logic       cs_ni,
  input  logic       op_valid_i,
  input  logic [7:0] op_i,
  input  logic       wip_i,
  input  logic       risk_ack_i,
  output logic       read_ok_o,
  output logic       write_ok_o,
  output logic       acc_o,
  output logic       rej_o,
  output logic [7:0] op_o,
  output logic       wel_o,
  output logic       deep_pd_o,
  output logic       risk_o
);
  logic puw_done, vsl_done, acc_now;

  pg_delay_cnt #(.LIMIT(T_PUW)) u_puw (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (vwi_ok_i),
    .done_o (puw_done)
  );

  pg_delay_cnt #(.LIMIT(T_VSL)) u_vsl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (vwi_ok_i && vmin_ok_i),
    .done_o (vsl_done)
  );

  assign read_ok_o  = vsl_done;
  assign write_ok_o = puw_done && vsl_done;

  pg_op_filter u_filt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .core_en_i  (vwi_ok_i),
    .cs_ni      (cs_ni),
    .op_valid_i (op_valid_i),
    .op_i       (op_i),
    .read_ok_i  (read_ok_o),
    .write_ok_i (write_ok_o),
    .acc_now_o  (acc_now),
    .acc_o      (acc_o),
    .rej_o      (rej_o),
    .op_o       (op_o)
  );

  pg_core_state u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .core_en_i (vwi_ok_i),
    .acc_i     (acc_now),
    .op_i      (op_i),
    .wel_o     (wel_o),
    .deep_pd_o (deep_pd_o)
  );

  pg_risk_flag u_risk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .vwi_ok_i (vwi_ok_i),
    .wip_i    (wip_i),
    .ack_i    (risk_ack_i),
    .risk_o   (risk_o)
  );

  p_gate_off_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vwi_ok_i |-> (!read_ok_o && !write_ok_o && !wel_o && !deep_pd_o));

  p_write_needs_read_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    write_ok_o |-> read_ok_o);

  p_read_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vmin_ok_i |=> !read_ok_o || $rose(vmin_ok_i) == 1'b0);

endmodule

// File: tb/sim_flash_pwr_gate.sv
module sim_flash_pwr_gate;
  localparam int unsigned T_PUW = 40;
  localparam int unsigned T_VSL = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vwi_ok = 1'b0, vmin_ok = 1'b0, cs_n = 1'b1, op_valid = 1'b0;
  logic [7:0] op = 8'h00;
  logic       wip = 1'b0, risk_ack = 1'b0;
  logic       read_ok, write_ok, acc, rej, wel, deep_pd, risk;
  logic [7:0] op_out;
  int         checks = 0, errors = 0;

  always #5 clk = ~clk;

  flash_pwr_gate #(.T_PUW(T_PUW), .T_VSL(T_VSL)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .vwi_ok_i(vwi_ok), .vmin_ok_i(vmin_ok),
    .cs_ni(cs_n), .op_valid_i(op_valid), .op_i(op), .wip_i(wip),
    .risk_ack_i(risk_ack), .read_ok_o(read_ok), .write_ok_o(write_ok),
    .acc_o(acc), .rej_o(rej), .op_o(op_out), .wel_o(wel),
    .deep_pd_o(deep_pd), .risk_o(risk)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // one strobe, one edge; caller samples at the following negedge
  task automatic send_op(input logic [7:0] code, input logic csn);
    op = code; cs_n = csn; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0; cs_n = 1'b1;
  endtask

  task automatic t_reset;
    chk("R1", "read_ok at reset", read_ok, 0);
    chk("R1", "write_ok at reset", write_ok, 0);
    chk("R8", "deep_pd at reset", deep_pd, 0);
    chk("R10", "risk at reset", risk, 0);
    chk("R1", "wel at reset", wel, 0);
  endtask

  task automatic t_powerup_gating;
    vwi_ok = 1'b1;
    repeat (5) @(negedge clk);
    vmin_ok = 1'b1;
    repeat (T_VSL - 1) @(negedge clk);
    chk("R3", "read_ok one edge early", read_ok, 0);
    @(negedge clk);                        // edge 17
    chk("R3", "read_ok at T_VSL", read_ok, 1);
    chk("R2", "write_ok still low", write_ok, 0);
    send_op(8'h06, 1'b0);                  // edge 18
    chk("R5", "WREN rejected", rej, 1);
    chk("R5", "WREN not accepted", acc, 0);
    chk("R6", "wel after rejected WREN", wel, 0);
    chk("R11", "op_o on reject", op_out, 8'h06);
    send_op(8'h03, 1'b0);                  // edge 19
    chk("R5", "READ accepted", acc, 1);
    chk("R11", "op_o on accept", op_out, 8'h03);
    send_op(8'hD8, 1'b0);                  // edge 20
    chk("R5", "SE rejected", rej, 1);
    chk("R11", "accept pulse ended", acc, 0);
    repeat (T_PUW - 21) @(negedge clk);    // edge 39
    chk("R2", "write_ok one edge early", write_ok, 0);
    @(negedge clk);                        // edge 40
    chk("R2", "write_ok at T_PUW", write_ok, 1);
  endtask

  task automatic t_wel_mode;
    send_op(8'h06, 1'b0);
    chk("R7", "WREN accepted", acc, 1);
    chk("R7", "wel set", wel, 1);
    send_op(8'h04, 1'b0);
    chk("R7", "wel cleared by WRDI", wel, 0);
    send_op(8'h02, 1'b0);
    chk("R5", "PP accepted once write_ok", acc, 1);
    send_op(8'hB9, 1'b0);
    chk("R8", "deep_pd set", deep_pd, 1);
    send_op(8'hAB, 1'b0);
    chk("R8", "deep_pd cleared", deep_pd, 0);
  endtask

  task automatic t_cs;
    send_op(8'h03, 1'b1);
    chk("R9", "no accept with cs high", acc, 0);
    chk("R9", "no reject with cs high", rej, 0);
    send_op(8'h06, 1'b1);
    chk("R9", "wel untouched with cs high", wel, 0);
  endtask

  task automatic t_restart;
    vmin_ok = 1'b0;
    #1;
    chk("R4", "read_ok drops at once", read_ok, 0);
    chk("R4", "write_ok drops at once", write_ok, 0);
    @(negedge clk);
    vmin_ok = 1'b1;
    repeat (T_VSL - 1) @(negedge clk);
    chk("R4", "read_ok still low after restart", read_ok, 0);
    send_op(8'h03, 1'b0);
    chk("R9", "no pulse while read gated", acc | rej, 0);
    chk("R4", "read_ok back after full delay", read_ok, 1);
    chk("R4", "write_ok back with read_ok", write_ok, 1);
  endtask

  task automatic t_powerdown;
    send_op(8'h06, 1'b0);
    send_op(8'hB9, 1'b0);
    chk("R7", "wel set before drop", wel, 1);
    wip = 1'b1;
    vwi_ok = 1'b0;
    #1;
    chk("R1", "read_ok off below threshold", read_ok, 0);
    chk("R1", "write_ok off below threshold", write_ok, 0);
    chk("R1", "wel off below threshold", wel, 0);
    chk("R1", "deep_pd off below threshold", deep_pd, 0);
    @(negedge clk);
    chk("R10", "risk set on drop with wip", risk, 1);
    wip = 1'b0;
    send_op(8'h03, 1'b0);
    chk("R1", "no answer below threshold", acc | rej, 0);
    vwi_ok = 1'b1;
    #1;
    chk("R1", "wel cleared by supply reset", wel, 0);
    chk("R8", "standby after supply reset", deep_pd, 0);
    repeat (3) @(negedge clk);
    chk("R10", "risk sticky", risk, 1);
    risk_ack = 1'b1;
    @(negedge clk);
    risk_ack = 1'b0;
    chk("R10", "risk cleared by ack", risk, 0);
    vwi_ok = 1'b0;
    @(negedge clk);
    chk("R10", "no risk without wip", risk, 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_powerup_gating();
    t_wel_mode();
    t_cs();
    t_restart();
    t_powerdown();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule